// File: doc/BRIEF.md
# Masked Flow Steering Table

This block is a small exact-match table that steers packets by their IPv4 address and port fields. A global field mask chooses which of the four header fields take part in matching: source address, destination address, source port and destination port. Every entry is compared in parallel with the probe. When more than one entry matches, the valid entry with the lowest index supplies the result.

Software manages the table through an indirect register port. It first writes the key fields and the result fields into staging registers. It then reads a command register. That read performs the insertion or the removal and returns a status code. The lookup port takes a header tuple and, one cycle later, returns a hit flag, an action code, a kernel index and a kernel identifier. Action code 0 is pass-through and action code 2 is steer-to-kernel. The table stores the action value without interpreting it.

Top module: `flow_steer_table`

## Requirements
- R1: After reset, every entry is invalid, the field mask and all staging registers read as 0, and `reg_rvalid`, `lk_rvalid` and `lk_hit` are 0.
- R2: A write sets a register, and a read returns it zero-extended one cycle later with `reg_rvalid` high. The writable registers are the mask at 0x00 (bit 0 source address, bit 1 destination address, bit 2 source port, bit 3 destination port), the key fields at 0x10–0x13 (source address, destination address, source port, destination port) and the result fields at 0x18–0x1A (action, kernel index, kernel id). `reg_rvalid` is low in every cycle that does not follow a read.
- R3: A read of 0x01 with no duplicate and a free slot stores the staged key and result in the lowest-indexed free entry and returns status 0.
- R4: A read of 0x01 returns status 2 and leaves the table unchanged when a valid entry equals the staged key on the masked fields. This check takes precedence over the full check.
- R5: A read of 0x01 with all entries valid and no duplicate returns status 1 and leaves the table unchanged.
- R6: A read of 0x02 invalidates the lowest-indexed valid entry that equals the staged key on the masked fields and returns status 0. If no entry matches, it returns status 3.
- R7: A lookup presented with `lk_valid` gives `lk_rvalid` one cycle later. On a hit, that cycle also carries `lk_hit`=1 and the stored action, kernel index and kernel id.
- R8: A lookup that matches no valid entry returns `lk_hit`=0 with action 0 (pass-through), kernel index 0 and kernel id 0.
- R9: Fields whose mask bit is 0 are ignored in lookups and in the duplicate and delete comparisons. A mask of 0 matches every valid entry.
- R10: When several valid entries match, the lowest-indexed one supplies the lookup result.
- R11: Writes to 0x01, 0x02 or an unmapped address change nothing. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; also triggers add/delete |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd_en` |
| reg_rdata | output | 32 | Read data or command status |
| lk_valid | input | 1 | Lookup request |
| lk_saddr | input | 32 | Probe source address |
| lk_daddr | input | 32 | Probe destination address |
| lk_sport | input | 16 | Probe source port |
| lk_dport | input | 16 | Probe destination port |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_action | output | 2 | Action code (0 pass-through, 2 steer) |
| lk_kidx | output | 8 | Kernel index |
| lk_kid | output | 16 | Kernel id |

## Verification
Both result paths have a latency of exactly one register. A read's data or status and a lookup's result appear in the cycle after the strobe. A table change made by a command read is visible to a lookup issued in the following cycle. The bench drives each stimulus on a falling edge and steps its behavioural model at that moment, using the pre-edge table state. At the next falling edge it compares every output with the model, so each compare lands in the one cycle where the result is due.

// File: rtl/flow_steer_pkg.sv
package flow_steer_pkg;

    parameter int REG_AW = 5;
    parameter int REG_DW = 32;
    parameter int ADDR_W = 32;
    parameter int PORT_W = 16;
    parameter int ACT_W  = 2;
    parameter int KIDX_W = 8;
    parameter int KID_W  = 16;
    parameter int MASK_W = 4;

    // register map
    localparam logic [REG_AW-1:0] RA_MASK  = 5'h00;
    localparam logic [REG_AW-1:0] RA_ADD   = 5'h01;
    localparam logic [REG_AW-1:0] RA_DEL   = 5'h02;
    localparam logic [REG_AW-1:0] RA_SADDR = 5'h10;
    localparam logic [REG_AW-1:0] RA_DADDR = 5'h11;
    localparam logic [REG_AW-1:0] RA_SPORT = 5'h12;
    localparam logic [REG_AW-1:0] RA_DPORT = 5'h13;
    localparam logic [REG_AW-1:0] RA_ACT   = 5'h18;
    localparam logic [REG_AW-1:0] RA_KIDX  = 5'h19;
    localparam logic [REG_AW-1:0] RA_KID   = 5'h1A;

    // mask bit positions
    localparam int MB_SADDR = 0;
    localparam int MB_DADDR = 1;
    localparam int MB_SPORT = 2;
    localparam int MB_DPORT = 3;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_FULL   = 2'd1,
        ST_DUP    = 2'd2,
        ST_ABSENT = 2'd3
    } op_status_e;

    typedef struct packed {
        logic [ADDR_W-1:0] saddr;
        logic [ADDR_W-1:0] daddr;
        logic [PORT_W-1:0] sport;
        logic [PORT_W-1:0] dport;
    } flow_key_t;

    typedef struct packed {
        logic [ACT_W-1:0]  action;
        logic [KIDX_W-1:0] kidx;
        logic [KID_W-1:0]  kid;
    } flow_res_t;

    // equality on the fields enabled by the mask only
    function automatic logic key_eq_masked(
        input logic [MASK_W-1:0] m,
        input flow_key_t         a,
        input flow_key_t         b
    );
        logic eq;
        eq = 1'b1;
        if (m[MB_SADDR] && (a.saddr != b.saddr)) eq = 1'b0;
        if (m[MB_DADDR] && (a.daddr != b.daddr)) eq = 1'b0;
        if (m[MB_SPORT] && (a.sport != b.sport)) eq = 1'b0;
        if (m[MB_DPORT] && (a.dport != b.dport)) eq = 1'b0;
        return eq;
    endfunction

endpackage

// File: rtl/fst_key_cmp.sv
module fst_key_cmp
    import flow_steer_pkg::*;
(
    input  logic              ent_valid,
    input  logic [MASK_W-1:0] mask,
    input  flow_key_t         ent_key,
    input  flow_key_t         probe,
    output logic              hit
);

    always_comb begin
        hit = ent_valid && key_eq_masked(mask, ent_key, probe);
    end

endmodule

// File: rtl/fst_first_set.sv
module fst_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // scan from the top so the lowest set bit is the last to win
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fst_store.sv
module fst_store
    import flow_steer_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_go,
    input  logic [IDX_W-1:0] add_idx,
    input  flow_key_t        add_key,
    input  flow_res_t        add_res,
    input  logic             del_go,
    input  logic [IDX_W-1:0] del_idx,
    output logic [N-1:0]     ent_valid,
    output flow_key_t        ent_key [N],
    output flow_res_t        ent_res [N]
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel_add;
        logic sel_del;

        assign sel_add = add_go && (add_idx == IDX_W'(g));
        assign sel_del = del_go && (del_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
            end else if (sel_add) begin
                ent_valid[g] <= 1'b1;
            end else if (sel_del) begin
                ent_valid[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_add) begin
                ent_key[g] <= add_key;
                ent_res[g] <= add_res;
            end
        end
    end

endmodule

// File: rtl/fst_ctrl.sv
module fst_ctrl
    import flow_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              dup_hit,
    input  logic              free_avail,
    input  logic              del_hit,
    output logic              add_go,
    output logic              del_go,
    output flow_key_t         stg_key,
    output flow_res_t         stg_res,
    output logic [MASK_W-1:0] mask,
    output logic              rvalid,
    output logic [REG_DW-1:0] rdata
);

    logic [1:0]        add_st;
    logic [1:0]        del_st;
    logic [REG_DW-1:0] rd_next;

    // status: duplicate outranks full
    always_comb begin
        if (dup_hit)          add_st = ST_DUP;
        else if (!free_avail) add_st = ST_FULL;
        else                  add_st = ST_OK;
        del_st = del_hit ? ST_OK : ST_ABSENT;
    end

    assign add_go = rd_en && (addr == RA_ADD) && (add_st == ST_OK);
    assign del_go = rd_en && (addr == RA_DEL) && del_hit;

    // staging and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask    <= '0;
            stg_key <= '0;
            stg_res <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_MASK:  mask          <= wdata[MASK_W-1:0];
                RA_SADDR: stg_key.saddr <= wdata[ADDR_W-1:0];
                RA_DADDR: stg_key.daddr <= wdata[ADDR_W-1:0];
                RA_SPORT: stg_key.sport <= wdata[PORT_W-1:0];
                RA_DPORT: stg_key.dport <= wdata[PORT_W-1:0];
                RA_ACT:   stg_res.action <= wdata[ACT_W-1:0];
                RA_KIDX:  stg_res.kidx  <= wdata[KIDX_W-1:0];
                RA_KID:   stg_res.kid   <= wdata[KID_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_MASK:  rd_next = REG_DW'(mask);
            RA_ADD:   rd_next = REG_DW'(add_st);
            RA_DEL:   rd_next = REG_DW'(del_st);
            RA_SADDR: rd_next = REG_DW'(stg_key.saddr);
            RA_DADDR: rd_next = REG_DW'(stg_key.daddr);
            RA_SPORT: rd_next = REG_DW'(stg_key.sport);
            RA_DPORT: rd_next = REG_DW'(stg_key.dport);
            RA_ACT:   rd_next = REG_DW'(stg_res.action);
            RA_KIDX:  rd_next = REG_DW'(stg_res.kidx);
            RA_KID:   rd_next = REG_DW'(stg_res.kid);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_next : '0;
        end
    end

endmodule

// File: rtl/flow_steer_table.sv
module flow_steer_table
    import flow_steer_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic              reg_rvalid,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_saddr,
    input  logic [ADDR_W-1:0] lk_daddr,
    input  logic [PORT_W-1:0] lk_sport,
    input  logic [PORT_W-1:0] lk_dport,
    output logic              lk_rvalid,
    output logic              lk_hit,
    output logic [ACT_W-1:0]  lk_action,
    output logic [KIDX_W-1:0] lk_kidx,
    output logic [KID_W-1:0]  lk_kid
);

    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    logic [N_ENTRIES-1:0] ent_valid;
    flow_key_t            ent_key [N_ENTRIES];
    flow_res_t            ent_res [N_ENTRIES];
    logic [N_ENTRIES-1:0] lk_match;
    logic [N_ENTRIES-1:0] stg_match;
    logic [MASK_W-1:0]    mask;
    flow_key_t            stg_key;
    flow_res_t            stg_res;
    flow_key_t            probe;
    logic                 add_go;
    logic                 del_go;
    logic                 free_avail;
    logic [IDX_W-1:0]     free_idx;
    logic                 stg_any;
    logic [IDX_W-1:0]     stg_idx;
    logic                 lk_any;
    logic [IDX_W-1:0]     lk_idx;

    assign probe = '{saddr: lk_saddr, daddr: lk_daddr, sport: lk_sport, dport: lk_dport};

    fst_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .dup_hit    (stg_any),
        .free_avail (free_avail),
        .del_hit    (stg_any),
        .add_go     (add_go),
        .del_go     (del_go),
        .stg_key    (stg_key),
        .stg_res    (stg_res),
        .mask       (mask),
        .rvalid     (reg_rvalid),
        .rdata      (reg_rdata)
    );

    fst_store #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .add_go    (add_go),
        .add_idx   (free_idx),
        .add_key   (stg_key),
        .add_res   (stg_res),
        .del_go    (del_go),
        .del_idx   (stg_idx),
        .ent_valid (ent_valid),
        .ent_key   (ent_key),
        .ent_res   (ent_res)
    );

    // two comparator banks: one against the probe, one against the staged key
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        fst_key_cmp u_lk_cmp (
            .ent_valid (ent_valid[g]),
            .mask      (mask),
            .ent_key   (ent_key[g]),
            .probe     (probe),
            .hit       (lk_match[g])
        );
        fst_key_cmp u_stg_cmp (
            .ent_valid (ent_valid[g]),
            .mask      (mask),
            .ent_key   (ent_key[g]),
            .probe     (stg_key),
            .hit       (stg_match[g])
        );
    end

    fst_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req   (~ent_valid),
        .found (free_avail),
        .idx   (free_idx)
    );

    fst_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick_stg (
        .req   (stg_match),
        .found (stg_any),
        .idx   (stg_idx)
    );

    fst_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick_lk (
        .req   (lk_match),
        .found (lk_any),
        .idx   (lk_idx)
    );

    // one-cycle lookup result; misses return pass-through zeros
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rvalid <= 1'b0;
            lk_hit    <= 1'b0;
            lk_action <= '0;
            lk_kidx   <= '0;
            lk_kid    <= '0;
        end else begin
            lk_rvalid <= lk_valid;
            if (lk_valid && lk_any) begin
                lk_hit    <= 1'b1;
                lk_action <= ent_res[lk_idx].action;
                lk_kidx   <= ent_res[lk_idx].kidx;
                lk_kid    <= ent_res[lk_idx].kid;
            end else begin
                lk_hit    <= 1'b0;
                lk_action <= '0;
                lk_kidx   <= '0;
                lk_kid    <= '0;
            end
        end
    end

endmodule

// File: rtl/flow_steer_table_chk.sv
module flow_steer_table_chk
    import flow_steer_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_rvalid,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              lk_valid,
    input logic              lk_rvalid,
    input logic              lk_hit,
    input logic [ACT_W-1:0]  lk_action,
    input logic [KIDX_W-1:0] lk_kidx,
    input logic [KID_W-1:0]  lk_kid,
    input logic [N-1:0]      ent_valid
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> reg_rvalid); // R2

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> !reg_rvalid); // R2

    AST_ADD_GROWS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == RA_ADD) |=>
            ((reg_rdata == 0) == ($countones(ent_valid) == $past($countones(ent_valid)) + 1))); // R3

    AST_ADD_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == RA_ADD) |=> (reg_rdata == 0) || $stable(ent_valid)); // R4

    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == RA_ADD && (&ent_valid)) |=> (reg_rdata != 0)); // R5

    AST_DEL_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == RA_DEL) |=>
            ((reg_rdata == 0) == ($countones(ent_valid) + 1 == $past($countones(ent_valid))))); // R6

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_rvalid); // R7

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (lk_rvalid && !lk_hit) |-> (lk_action == '0 && lk_kidx == '0 && lk_kid == '0)); // R8

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ent_valid == '0) |=> !lk_hit); // R8

endmodule

bind flow_steer_table flow_steer_table_chk #(.N(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .lk_valid   (lk_valid),
    .lk_rvalid  (lk_rvalid),
    .lk_hit     (lk_hit),
    .lk_action  (lk_action),
    .lk_kidx    (lk_kidx),
    .lk_kid     (lk_kid),
    .ent_valid  (ent_valid)
);

// File: tb/flow_steer_table_bench.sv
module flow_steer_table_bench;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        b_wr_en, b_rd_en, b_lk_valid;
    logic [4:0]  b_addr;
    logic [31:0] b_wdata;
    logic [31:0] b_saddr, b_daddr;
    logic [15:0] b_sport, b_dport;
    logic        reg_rvalid, lk_rvalid, lk_hit;
    logic [31:0] reg_rdata;
    logic [1:0]  lk_action;
    logic [7:0]  lk_kidx;
    logic [15:0] lk_kid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    flow_steer_table #(.N_ENTRIES(N)) u_flow_steer_table (
        .clk(clk), .rst(rst),
        .reg_wr_en(b_wr_en), .reg_rd_en(b_rd_en), .reg_addr(b_addr), .reg_wdata(b_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .lk_valid(b_lk_valid), .lk_saddr(b_saddr), .lk_daddr(b_daddr),
        .lk_sport(b_sport), .lk_dport(b_dport),
        .lk_rvalid(lk_rvalid), .lk_hit(lk_hit), .lk_action(lk_action),
        .lk_kidx(lk_kidx), .lk_kid(lk_kid)
    );

    // behavioural reference model
    bit          m_valid [N];
    logic [31:0] m_sa [N], m_da [N];
    logic [15:0] m_sp [N], m_dp [N];
    logic [1:0]  m_act [N];
    logic [7:0]  m_kx [N];
    logic [15:0] m_kd [N];
    logic [3:0]  m_mask;
    logic [31:0] s_sa, s_da;
    logic [15:0] s_sp, s_dp;
    logic [1:0]  s_act;
    logic [7:0]  s_kx;
    logic [15:0] s_kd;

    bit          e_rvalid, e_lk_rvalid, e_hit;
    logic [31:0] e_rdata;
    logic [1:0]  e_act;
    logic [7:0]  e_kx;
    logic [15:0] e_kd;
    string       e_tag, cur_tag;

    function automatic bit model_eq(int i, logic [31:0] sa, logic [31:0] da,
                                    logic [15:0] sp, logic [15:0] dp);
        if (!m_valid[i]) return 0;
        if (m_mask[0] && m_sa[i] != sa) return 0;
        if (m_mask[1] && m_da[i] != da) return 0;
        if (m_mask[2] && m_sp[i] != sp) return 0;
        if (m_mask[3] && m_dp[i] != dp) return 0;
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_mask = 0; s_sa = 0; s_da = 0; s_sp = 0; s_dp = 0;
        s_act = 0; s_kx = 0; s_kd = 0;
        e_rvalid = 0; e_lk_rvalid = 0; e_hit = 0;
        e_rdata = 0; e_act = 0; e_kx = 0; e_kd = 0; e_tag = "R1";
    endtask

    task automatic model_step();
        int first;
        int freei;
        e_lk_rvalid = b_lk_valid;
        e_hit = 0; e_act = 0; e_kx = 0; e_kd = 0;
        if (b_lk_valid) begin
            for (int i = 0; i < N; i++) begin
                if (!e_hit && model_eq(i, b_saddr, b_daddr, b_sport, b_dport)) begin
                    e_hit = 1; e_act = m_act[i]; e_kx = m_kx[i]; e_kd = m_kd[i];
                end
            end
        end
        e_rvalid = b_rd_en;
        e_rdata  = 0;
        if (b_rd_en) begin
            first = -1;
            for (int i = N - 1; i >= 0; i--)
                if (model_eq(i, s_sa, s_da, s_sp, s_dp)) first = i;
            case (b_addr)
                5'h00: e_rdata = {28'd0, m_mask};
                5'h01: begin
                    freei = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) freei = i;
                    if (first >= 0)     e_rdata = 2;
                    else if (freei < 0) e_rdata = 1;
                    else begin
                        e_rdata = 0;
                        m_valid[freei] = 1;
                        m_sa[freei] = s_sa; m_da[freei] = s_da;
                        m_sp[freei] = s_sp; m_dp[freei] = s_dp;
                        m_act[freei] = s_act; m_kx[freei] = s_kx; m_kd[freei] = s_kd;
                    end
                end
                5'h02: begin
                    if (first >= 0) begin e_rdata = 0; m_valid[first] = 0; end
                    else e_rdata = 3;
                end
                5'h10: e_rdata = s_sa;
                5'h11: e_rdata = s_da;
                5'h12: e_rdata = {16'd0, s_sp};
                5'h13: e_rdata = {16'd0, s_dp};
                5'h18: e_rdata = {30'd0, s_act};
                5'h19: e_rdata = {24'd0, s_kx};
                5'h1A: e_rdata = {16'd0, s_kd};
                default: e_rdata = 0;
            endcase
        end
        if (b_wr_en) begin
            case (b_addr)
                5'h00: m_mask = b_wdata[3:0];
                5'h10: s_sa = b_wdata;
                5'h11: s_da = b_wdata;
                5'h12: s_sp = b_wdata[15:0];
                5'h13: s_dp = b_wdata[15:0];
                5'h18: s_act = b_wdata[1:0];
                5'h19: s_kx = b_wdata[7:0];
                5'h1A: s_kd = b_wdata[15:0];
                default: ;
            endcase
        end
        e_tag = cur_tag;
    endtask

    task automatic compare();
        if (e_rvalid || reg_rvalid) begin
            checks++;
            if (reg_rvalid !== e_rvalid || (e_rvalid && reg_rdata !== e_rdata)) begin
                fails++;
                $display("FAIL %s reg read: got v=%0b d=%h expected v=%0b d=%h",
                         e_tag, reg_rvalid, reg_rdata, e_rvalid, e_rdata);
            end
        end
        if (e_lk_rvalid || lk_rvalid) begin
            checks++;
            if (lk_rvalid !== e_lk_rvalid || lk_hit !== e_hit || lk_action !== e_act ||
                lk_kidx !== e_kx || lk_kid !== e_kd) begin
                fails++;
                $display("FAIL %s lookup: got v=%0b h=%0b a=%0d k=%0d id=%h expected v=%0b h=%0b a=%0d k=%0d id=%h",
                         e_tag, lk_rvalid, lk_hit, lk_action, lk_kidx, lk_kid,
                         e_lk_rvalid, e_hit, e_act, e_kx, e_kd);
            end
        end
    endtask

    task automatic idle_inputs();
        b_wr_en = 0; b_rd_en = 0; b_lk_valid = 0; b_addr = 0; b_wdata = 0;
    endtask

    task automatic run_cycle();
        model_step();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        b_wr_en = 1; b_addr = a; b_wdata = d;
        run_cycle();
    endtask

    task automatic rd(input logic [4:0] a);
        b_rd_en = 1; b_addr = a;
        run_cycle();
    endtask

    task automatic look(input logic [31:0] sa, input logic [31:0] da,
                        input logic [15:0] sp, input logic [15:0] dp);
        b_lk_valid = 1; b_saddr = sa; b_daddr = da; b_sport = sp; b_dport = dp;
        run_cycle();
    endtask

    task automatic stage(input logic [15:0] sp, input logic [31:0] da,
                         input logic [1:0] act, input logic [7:0] kx, input logic [15:0] kd);
        wr(5'h10, 32'h0A00_0001);
        wr(5'h11, da);
        wr(5'h12, {16'd0, sp});
        wr(5'h13, 32'd4791);
        wr(5'h18, {30'd0, act});
        wr(5'h19, {24'd0, kx});
        wr(5'h1A, {16'd0, kd});
    endtask

    localparam logic [31:0] DA = 32'hC0A8_0001;

    initial begin
        idle_inputs();
        b_saddr = 0; b_daddr = 0; b_sport = 0; b_dport = 0;
        rst = 1;
        model_reset();
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state at the ports
        checks++;
        if (reg_rvalid !== 0 || lk_rvalid !== 0 || lk_hit !== 0) begin
            fails++;
            $display("FAIL R1 reset outputs: got %0b%0b%0b expected 000", reg_rvalid, lk_rvalid, lk_hit);
        end
        rd(5'h00); rd(5'h10); rd(5'h18); rd(5'h1A);
        look(32'h1, 32'h2, 16'd3, 16'd4);

        // R2: register write and readback
        cur_tag = "R2";
        wr(5'h00, 32'hF);
        stage(16'd1000, DA, 2'd2, 8'd0, 16'h0100);
        rd(5'h00); rd(5'h10); rd(5'h11); rd(5'h12); rd(5'h13);
        rd(5'h18); rd(5'h19); rd(5'h1A);

        // R3: add into lowest free slot
        cur_tag = "R3";
        rd(5'h01);
        cur_tag = "R7";
        look(32'h0A00_0001, DA, 16'd1000, 16'd4791);
        cur_tag = "R8";
        look(32'h0A00_0001, DA, 16'd9999, 16'd4791);

        // R4: duplicate add
        cur_tag = "R4";
        rd(5'h01);

        cur_tag = "R3";
        for (int i = 1; i < N; i++) begin
            stage(16'(1000 + i), DA, 2'(i % 3), 8'(i), 16'(16'h0100 + i));
            rd(5'h01);
        end
        // R5: full table
        cur_tag = "R5";
        stage(16'd2000, DA, 2'd2, 8'd9, 16'h0999);
        rd(5'h01);
        // R4: duplicate outranks full
        cur_tag = "R4";
        stage(16'd1003, DA, 2'd2, 8'd9, 16'h0999);
        rd(5'h01);
        cur_tag = "R7";
        look(32'h0A00_0001, DA, 16'd1003, 16'd4791);

        // R9 / R10: destination-address-only mask, lowest index wins
        cur_tag = "R9";
        wr(5'h00, 32'h2);
        look(32'h0505_0505, DA, 16'd5555, 16'd7);
        cur_tag = "R10";
        look(32'h0, DA, 16'd0, 16'd0);

        // R6: delete under the mask removes entry 0
        cur_tag = "R6";
        stage(16'd1234, DA, 2'd0, 8'd0, 16'd0);
        rd(5'h02);
        cur_tag = "R10";
        look(32'h0, DA, 16'd0, 16'd0);
        cur_tag = "R6";
        wr(5'h11, 32'h0101_0101);
        rd(5'h02);

        // R3: slot 0 reused
        cur_tag = "R3";
        wr(5'h00, 32'hF);
        stage(16'd3000, DA, 2'd2, 8'd42, 16'hBEEF);
        rd(5'h01);
        cur_tag = "R7";
        look(32'h0A00_0001, DA, 16'd3000, 16'd4791);

        // R11: writes to command and unmapped addresses ignored
        cur_tag = "R11";
        wr(5'h01, 32'hFFFF_FFFF);
        wr(5'h02, 32'hFFFF_FFFF);
        wr(5'h07, 32'h1234_5678);
        rd(5'h07);
        rd(5'h00);
        look(32'h0A00_0001, DA, 16'd3000, 16'd4791);
        look(32'h0A00_0001, DA, 16'd1001, 16'd4791);

        // R9: mask 0 matches everything; delete all then miss
        cur_tag = "R9";
        wr(5'h00, 32'h0);
        look(32'h9, 32'h9, 16'd9, 16'd9);
        cur_tag = "R6";
        for (int i = 0; i < N; i++) rd(5'h02);
        rd(5'h02);
        cur_tag = "R8";
        look(32'h9, 32'h9, 16'd9, 16'd9);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule